// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block is the serial core of an SPI master. It takes words from a transmit FIFO through a show-ahead interface (`tx_valid`, `tx_data`, `tx_pop`), shifts each one out on `mosi` while it drives `sclk`, and packs the bits it collects into a word that it pushes toward a receive FIFO. The serial clock runs at the system clock divided by a build-time parameter. No run-time rate setting exists.

Static inputs set the bus format: the clock idle level, which of the two edges of each bit samples data, whether the least significant bit goes first, and an internal loopback that feeds the outgoing bit back into the receiver. A transmit-inhibit input keeps the engine idle while software fills the FIFO. When inhibit is released, every queued word goes out with no gap between words. Slave selects either track a 32-bit pattern continuously (manual mode) or apply that pattern only while a word is on the bus. Three single-cycle event pulses report the end of a burst, a starved transfer and a dropped receive word.

Top module: `spi_xfer_engine`

## Requirements
- R1: During and right after reset, `ss_n` is all ones, `sclk` equals `cpol`, `mosi` is 0, and no push or event pulse is raised.
- R2: No word is popped while `tx_inhibit` is high, even with `tx_valid` high. After inhibit falls, every queued word is sent back to back, so N words take exactly N*2*WORD_W*CLK_DIV cycles from the first pop to the empty event.
- R3: While idle, `sclk` rests at `cpol`. With `cpha`=0 data is sampled on the first edge of each bit, and with `cpha`=1 on the second edge.
- R4: With `lsb_first`=1, bit 0 of a word is sent and received first. With `lsb_first`=0, bit WORD_W-1 goes first.
- R5: With `loopback`=1 the received bit is the engine's own `mosi` value and `miso` is ignored.
- R6: With `manual_ss`=1, `ss_n` equals `ss_pattern` one cycle later, whether or not a word is active, and it stays asserted between consecutive words.
- R7: With `manual_ss`=0, `ss_n` equals `ss_pattern` while a word is being shifted and is all ones otherwise.
- R8: Each `sclk` half period lasts exactly CLK_DIV system clock cycles.
- R9: `ev_tx_empty` pulses for one cycle after a word finishes with `tx_valid` low.
- R10: `ev_tx_underrun` pulses for one cycle when a word finishes with `tx_valid` low while `manual_ss`=1, because the slave is still held selected.
- R11: When a word finishes with `rx_full` high, `ev_rx_overrun` pulses, `rx_push` stays low and the word is dropped.
- R12: Each completed word with `rx_full` low raises `rx_push` for exactly one cycle, and `rx_data` holds the received word.
- R13: While `enable` or `master_en` is low, nothing is popped, `sclk` equals `cpol` and `mosi` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Engine enable |
| master_en | input | 1 | Master-mode flag. The engine runs only when this is set |
| tx_inhibit | input | 1 | Holds off the start of new words |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | 0: sample on the first edge of a bit. 1: sample on the second edge |
| lsb_first | input | 1 | Bit order select |
| loopback | input | 1 | Receive from own `mosi` instead of `miso` |
| manual_ss | input | 1 | Slave select follows the pattern continuously |
| ss_pattern | input | SS_W | Active-low slave-select pattern |
| tx_valid | input | 1 | Transmit FIFO holds a word |
| tx_data | input | WORD_W | Head word of the transmit FIFO |
| tx_pop | output | 1 | Takes the head word this cycle |
| rx_full | input | 1 | Receive FIFO cannot accept a word |
| rx_push | output | 1 | Received word is valid |
| rx_data | output | WORD_W | Received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | SS_W | Slave selects, active low |
| ev_tx_empty | output | 1 | Burst finished, FIFO empty |
| ev_tx_underrun | output | 1 | Word finished with no successor while the slave is held selected |
| ev_rx_overrun | output | 1 | Received word dropped |

## Verification
All four combinations of clock idle level and sample edge are tried, with a bench slave that replies with a word different from the one sent. This shows whether the engine samples on the correct edge, because a wrong edge shifts the received bits by one position. Asymmetric words in both bit orders show whether the order is reversed. Loopback runs use a reply that differs from the transmitted word, so any leakage from `miso` is visible. An inhibited preload of three words is timed from the first pop to the empty event, which shows whether the burst has gaps and whether the divider is correct. Runs with manual select, a full receive FIFO and a disabled engine show the select behaviour, the underrun and overrun events and the idle levels.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } eng_state_t;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb_first;
        logic loopback;
    } spi_mode_t;

    // Receive sampling happens on even edges for phase 0 and on odd edges for phase 1.
    function automatic logic is_sample_edge(input logic cpha, input logic odd_edge);
        return odd_edge == cpha;
    endfunction

    // The output advances on odd edges for phase 0. For phase 1 it advances on
    // even edges other than the very first.
    function automatic logic is_shift_edge(input logic cpha, input logic odd_edge,
                                           input logic first_edge);
        return cpha ? (!odd_edge && !first_edge) : odd_edge;
    endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt == TOP)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    assign tick = run && (cnt == TOP);
endmodule

// File: rtl/spi_word_shift.sv
module spi_word_shift #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              lsb_first,
    input  logic              shift_en,
    input  logic              sample_en,
    input  logic              rx_bit,
    output logic              out_bit,
    output logic [WORD_W-1:0] rx_word_nxt
);
    logic [WORD_W-1:0] tx_sr;
    logic [WORD_W-1:0] rx_sr;

    always_ff @(posedge clk) begin
        if (rst)
            tx_sr <= '0;
        else if (load)
            tx_sr <= load_word;
        else if (shift_en)
            tx_sr <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
    end

    assign out_bit = lsb_first ? tx_sr[0] : tx_sr[WORD_W-1];

    always_comb begin
        rx_word_nxt = rx_sr;
        if (sample_en)
            rx_word_nxt = lsb_first ? {rx_bit, rx_sr[WORD_W-1:1]}
                                    : {rx_sr[WORD_W-2:0], rx_bit};
    end

    always_ff @(posedge clk) begin
        if (rst)
            rx_sr <= '0;
        else
            rx_sr <= rx_word_nxt;
    end
endmodule

// File: rtl/spi_ss_drive.sv
module spi_ss_drive #(
    parameter int SS_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            manual,
    input  logic            active,
    input  logic [SS_W-1:0] pattern,
    output logic [SS_W-1:0] ss_n
);
    always_ff @(posedge clk) begin
        if (rst)
            ss_n <= '1;
        else if (manual || active)
            ss_n <= pattern;
        else
            ss_n <= '1;
    end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_xfer_pkg::*;
#(
    parameter int WORD_W  = 8,
    parameter int CLK_DIV = 2,
    parameter int SS_W    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              master_en,
    input  logic              tx_inhibit,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              loopback,
    input  logic              manual_ss,
    input  logic [SS_W-1:0]   ss_pattern,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [SS_W-1:0]   ss_n,
    output logic              ev_tx_empty,
    output logic              ev_tx_underrun,
    output logic              ev_rx_overrun
);
    localparam int EDGES = 2 * WORD_W;
    localparam int EW    = $clog2(EDGES);
    localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

    spi_mode_t   mode;
    eng_state_t  state;
    logic [EW-1:0] edge_idx;
    logic        sclk_q;
    logic        go, busy, tick, word_done, start, ss_active;
    logic        sample_en, shift_en, out_bit, rx_bit;
    logic [WORD_W-1:0] rx_word_nxt;

    assign mode = '{cpol: cpol, cpha: cpha, lsb_first: lsb_first, loopback: loopback};

    assign go        = enable && master_en;
    assign busy      = (state == ST_SHIFT);
    assign word_done = tick && (edge_idx == LAST_EDGE);
    assign start     = go && !tx_inhibit && tx_valid && (!busy || word_done);
    assign tx_pop    = start;
    assign ss_active = go && (start || (busy && !word_done));

    assign sample_en = tick && is_sample_edge(mode.cpha, edge_idx[0]);
    assign shift_en  = tick && is_shift_edge(mode.cpha, edge_idx[0], edge_idx == '0);
    assign rx_bit    = mode.loopback ? out_bit : miso;

    spi_clk_div #(.CLK_DIV(CLK_DIV)) i_div (
        .clk (clk),
        .rst (rst),
        .run (busy && go),
        .tick(tick)
    );

    spi_word_shift #(.WORD_W(WORD_W)) i_shift (
        .clk        (clk),
        .rst        (rst),
        .load       (start),
        .load_word  (tx_data),
        .lsb_first  (mode.lsb_first),
        .shift_en   (shift_en),
        .sample_en  (sample_en),
        .rx_bit     (rx_bit),
        .out_bit    (out_bit),
        .rx_word_nxt(rx_word_nxt)
    );

    spi_ss_drive #(.SS_W(SS_W)) i_ss (
        .clk    (clk),
        .rst    (rst),
        .manual (manual_ss),
        .active (ss_active),
        .pattern(ss_pattern),
        .ss_n   (ss_n)
    );

    // Sequencing of words and edges
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            edge_idx <= '0;
            sclk_q   <= 1'b0;
        end else if (!go) begin
            state    <= ST_IDLE;
            edge_idx <= '0;
        end else if (start) begin
            state    <= ST_SHIFT;
            edge_idx <= '0;
            sclk_q   <= mode.cpol;
        end else if (word_done) begin
            state    <= ST_IDLE;
            edge_idx <= '0;
        end else if (tick) begin
            edge_idx <= edge_idx + EW'(1);
            sclk_q   <= ~sclk_q;
        end
    end

    // Completion results and event pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_push        <= 1'b0;
            rx_data        <= '0;
            ev_tx_empty    <= 1'b0;
            ev_tx_underrun <= 1'b0;
            ev_rx_overrun  <= 1'b0;
        end else begin
            rx_push        <= 1'b0;
            ev_tx_empty    <= 1'b0;
            ev_tx_underrun <= 1'b0;
            ev_rx_overrun  <= 1'b0;
            if (word_done) begin
                if (rx_full) begin
                    ev_rx_overrun <= 1'b1;
                end else begin
                    rx_push <= 1'b1;
                    rx_data <= rx_word_nxt;
                end
                if (!tx_valid) begin
                    ev_tx_empty    <= 1'b1;
                    ev_tx_underrun <= manual_ss;
                end
            end
        end
    end

    assign sclk = busy ? sclk_q : mode.cpol;
    assign mosi = busy && out_bit;
endmodule

// File: rtl/spi_xfer_chk.sv
module spi_xfer_chk #(
    parameter int SS_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            enable,
    input logic            master_en,
    input logic            tx_inhibit,
    input logic            manual_ss,
    input logic [SS_W-1:0] ss_pattern,
    input logic            cpol,
    input logic            busy,
    input logic            sclk,
    input logic            mosi,
    input logic            tx_pop,
    input logic            rx_push,
    input logic            ev_rx_overrun,
    input logic [SS_W-1:0] ss_n
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1
    always_ff @(posedge clk) begin
        if (rst_q && !rst)
            reset_ss_chk: assert (ss_n == '1);
    end

    // R13
    off_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(enable && master_en) |=> (sclk == cpol) && !mosi);

    // R2
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_inhibit && !busy) |-> !tx_pop);

    // R11
    overrun_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ev_rx_overrun |-> !rx_push);

    // R6
    manual_ss_chk: assert property (@(posedge clk) disable iff (rst)
        manual_ss |=> ss_n == $past(ss_pattern));

    // R7
    auto_ss_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!manual_ss && !$past(manual_ss) && !busy) |-> ss_n == '1);
endmodule

bind spi_xfer_engine spi_xfer_chk #(.SS_W(SS_W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .master_en    (master_en),
    .tx_inhibit   (tx_inhibit),
    .manual_ss    (manual_ss),
    .ss_pattern   (ss_pattern),
    .cpol         (cpol),
    .busy         (busy),
    .sclk         (sclk),
    .mosi         (mosi),
    .tx_pop       (tx_pop),
    .rx_push      (rx_push),
    .ev_rx_overrun(ev_rx_overrun),
    .ss_n         (ss_n)
);

// File: tb/test_spi_xfer_engine.sv
module test_spi_xfer_engine;
    localparam int W   = 8;
    localparam int DIV = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0, master_en = 1'b0, tx_inhibit = 1'b0;
    logic cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0, loopback = 1'b0;
    logic manual_ss = 1'b0;
    logic [31:0] ss_pattern = 32'hFFFF_FFFE;
    logic tx_valid, tx_pop, rx_full = 1'b0, rx_push;
    logic [W-1:0] tx_data, rx_data;
    logic sclk, mosi, miso = 1'b0;
    logic [31:0] ss_n;
    logic ev_tx_empty, ev_tx_underrun, ev_rx_overrun;

    always #2.5 clk = ~clk;

    spi_xfer_engine #(.WORD_W(W), .CLK_DIV(DIV), .SS_W(32)) i_spi_xfer_engine (
        .clk(clk), .rst(rst), .enable(enable), .master_en(master_en),
        .tx_inhibit(tx_inhibit), .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first),
        .loopback(loopback), .manual_ss(manual_ss), .ss_pattern(ss_pattern),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop), .rx_full(rx_full),
        .rx_push(rx_push), .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso),
        .ss_n(ss_n), .ev_tx_empty(ev_tx_empty), .ev_tx_underrun(ev_tx_underrun),
        .ev_rx_overrun(ev_rx_overrun)
    );

    int checks = 0, errors = 0;
    int empty_cnt = 0, under_cnt = 0, over_cnt = 0, push_cnt = 0, pop_cnt = 0;
    bit finished = 1'b0;

    logic [W-1:0] txq[$], replyq[$], exp_mosi[$], exp_rx[$];
    assign tx_valid = txq.size() > 0;
    assign tx_data  = tx_valid ? txq[0] : '0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Pop capture happens at the clock edge; the queue itself changes at the falling edge.
    logic take = 1'b0;
    always @(posedge clk) take <= tx_pop;

    // Bench slave and result monitor, all evaluated at the falling edge
    bit hold = 1'b1;
    logic prev_sclk = 1'b0, prev_mosi = 1'b0;
    logic [W-1:0] rep = '0, cap = '0;
    int rbit = 0, sbit = 0;
    bit watch_ss = 1'b0;

    function automatic logic rep_bit(input int k);
        if (k >= W) return 1'b0;
        return lsb_first ? rep[k] : rep[W-1-k];
    endfunction

    always @(negedge clk) begin
        if (!hold && !rst && sclk != prev_sclk) begin
            logic leading;
            leading = (sclk != cpol);
            if (leading == !cpha) begin
                if (lsb_first) cap[sbit] = prev_mosi;
                else           cap[W-1-sbit] = prev_mosi;
                sbit++;
                if (sbit == W) begin
                    sbit = 0;
                    // R3 R4: bits seen by the slave on its sampling edges
                    if (exp_mosi.size() > 0) check("R3/R4 mosi word", cap, exp_mosi.pop_front());
                    else check("R3 unexpected word", 1, 0);
                end
            end else if (cpha) begin
                miso <= rep_bit(rbit);
                rbit++;
            end else begin
                rbit++;
                miso <= rep_bit(rbit);
            end
        end
        if (take) begin
            pop_cnt++;
            void'(txq.pop_front());
            rep  = replyq.pop_front();
            rbit = 0;
            if (!cpha) miso <= rep_bit(0);
        end
        if (rx_push) begin
            push_cnt++;
            // R12: one push per completed word, carrying the received bits
            if (exp_rx.size() > 0) check("R12 rx word", rx_data, exp_rx.pop_front());
            else check("R12 unexpected push", 1, 0);
        end
        if (ev_tx_empty) empty_cnt++;
        if (ev_tx_underrun) under_cnt++;
        if (ev_rx_overrun) over_cnt++;
        if (watch_ss && ss_n !== ss_pattern) begin
            checks++; errors++;
            $display("FAIL R6 ss_n during burst actual=%0h expected=%0h", ss_n, ss_pattern);
        end
        prev_sclk = sclk;
        prev_mosi = mosi;
    end

    task automatic queue_word(input logic [W-1:0] tx, input logic [W-1:0] reply, input bit keep);
        @(negedge clk);
        txq.push_back(tx);
        replyq.push_back(reply);
        exp_mosi.push_back(tx);
        if (keep) exp_rx.push_back(loopback ? tx : reply);
    endtask

    task automatic set_mode(input logic p, input logic h, input logic l, input logic lb);
        @(negedge clk);
        hold = 1'b1;
        cpol = p; cpha = h; lsb_first = l; loopback = lb;
        repeat (2) @(negedge clk);
        hold = 1'b0;
    endtask

    task automatic wait_empty(input int target);
        int n = 0;
        while (empty_cnt < target && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check("R9 burst completion", empty_cnt, target);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int e0, n;
        repeat (4) @(negedge clk);
        // R1: reset values
        check("R1 ss_n in reset", ss_n, 32'hFFFF_FFFF);
        check("R1 sclk in reset", sclk, 0);
        check("R1 mosi in reset", mosi, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1 ss_n after reset", ss_n, 32'hFFFF_FFFF);
        check("R1 no push after reset", {rx_push, ev_tx_empty, ev_rx_overrun}, 0);
        enable = 1'b1; master_en = 1'b1;
        set_mode(0, 0, 0, 0);

        // Mode 0, MSB first, automatic select
        queue_word(8'hA5, 8'h3C, 1);
        repeat (3) @(negedge clk);
        check("R7 ss_n during word", ss_n, 32'hFFFF_FFFE);
        wait_empty(1);
        check("R7 ss_n after word", ss_n, 32'hFFFF_FFFF);
        check("R12 push count mode0", push_cnt, 1);

        // Mode 3
        set_mode(1, 1, 0, 0);
        check("R3 idle level high", sclk, 1);
        queue_word(8'h81, 8'h7E, 1);
        queue_word(8'h12, 8'hC4, 1);
        wait_empty(2);
        // Modes 1 and 2 with LSB first
        set_mode(0, 1, 1, 0);
        queue_word(8'h01, 8'h80, 1);
        wait_empty(3);
        set_mode(1, 0, 1, 0);
        check("R3 idle level high mode2", sclk, 1);
        queue_word(8'hC8, 8'h35, 1);
        wait_empty(4);

        // R5: loopback ignores miso (reply differs from sent word)
        set_mode(0, 0, 0, 1);
        queue_word(8'h96, 8'h0F, 1);
        wait_empty(5);
        set_mode(1, 1, 1, 1);
        queue_word(8'h4B, 8'hF0, 1);
        wait_empty(6);
        check("R5 loopback words received", push_cnt, 7);

        // R2 R8: inhibited preload, then a gapless burst
        set_mode(0, 0, 0, 0);
        tx_inhibit = 1'b1;
        e0 = pop_cnt;
        queue_word(8'h11, 8'hEE, 1);
        queue_word(8'h22, 8'hDD, 1);
        queue_word(8'h33, 8'hCC, 1);
        repeat (50) @(negedge clk);
        check("R2 no pop while inhibited", pop_cnt, e0);
        check("R2 sclk idle while inhibited", sclk, 0);
        tx_inhibit = 1'b0;
        @(negedge clk);
        while (!take) @(negedge clk);
        n = 0;
        while (!ev_tx_empty && n < 1000) begin @(negedge clk); n++; end
        check("R2/R8 burst length in cycles", n, 3 * 2 * W * DIV);
        wait_empty(7);

        // R6 R10: manual select held across words, underrun at the end
        ss_pattern = 32'hFFFF_FFFD;
        manual_ss = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 manual ss_n while idle", ss_n, 32'hFFFF_FFFD);
        watch_ss = 1'b1;
        queue_word(8'h5A, 8'hA5, 1);
        queue_word(8'hE1, 8'h1E, 1);
        wait_empty(8);
        watch_ss = 1'b0;
        check("R10 underrun count", under_cnt, 1);
        check("R6 manual ss_n after burst", ss_n, 32'hFFFF_FFFD);
        manual_ss = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 ss_n released", ss_n, 32'hFFFF_FFFF);

        // R11: full receive FIFO drops the word
        e0 = push_cnt;
        rx_full = 1'b1;
        queue_word(8'h77, 8'h88, 0);
        wait_empty(9);
        rx_full = 1'b0;
        check("R11 overrun count", over_cnt, 1);
        check("R11 no push on overrun", push_cnt, e0);
        check("R10 no underrun in auto select", under_cnt, 1);

        // R13: disabled or not master keeps the bus idle
        set_mode(1, 0, 0, 0);
        enable = 1'b0;
        e0 = pop_cnt;
        queue_word(8'hF3, 8'h3F, 1);
        repeat (40) @(negedge clk);
        check("R13 no pop while disabled", pop_cnt, e0);
        check("R13 sclk at idle level", sclk, 1);
        check("R13 mosi low", mosi, 0);
        enable = 1'b1; master_en = 1'b0;
        repeat (40) @(negedge clk);
        check("R13 no pop without master", pop_cnt, e0);
        master_en = 1'b1;
        wait_empty(10);

        check("R3 all slave words seen", exp_mosi.size(), 0);
        check("R12 all rx words seen", exp_rx.size(), 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule